// File: doc/BRIEF.md
# Enhanced Second-Chance Victim Selector

This block keeps a referenced flag and a modified flag for each of a fixed set of page frames and picks the frame to evict when a page fault has to be serviced. Reads and writes to frames are reported on an access port. A read marks the frame referenced. A write marks it referenced and modified. On a fault the selector walks the frames in a ring, one frame per cycle, starting at a rotating hand. It prefers a frame that is both unreferenced and unmodified.

While it walks, every unreferenced but modified frame it passes is appended to a pending write-back list, which holds each frame at most once. When the list holds at least a configured number of frames, a write-back request is raised toward the agent that copies pages to backing storage. Each acknowledge from that agent retires the oldest listed frame and clears its modified flag. Once a victim has been chosen, every referenced flag is cleared, so that each fault opens a fresh observation window.

Top module: `esc_victim_sel`

## Requirements
- R1: After reset, no frame is referenced or modified, the hand is at frame 0, the write-back list is empty, `fault_ready` is 1, and both `victim_valid` and `wb_req` are 0.
- R2: An access with `acc_valid`=1 sets the referenced flag of `acc_frame`. If `acc_write`=1 it also sets that frame's modified flag. A read (`acc_write`=0) leaves the modified flag unchanged.
- R3: A fault is accepted only on a clock edge where `fault_ready`=1. From the acceptance edge until the victim is presented, `fault_ready` is 0 and `fault_req` is ignored.
- R4: The frame at offset j from the hand is examined on the (j+1)-th edge after the acceptance edge. If the first unreferenced, unmodified frame is at offset j, it is the victim, and `victim_valid` is high in the cycle that follows that edge.
- R5: `victim_valid` is a single-cycle pulse, with the chosen index on `victim_frame`.
- R6: If a full ring of N frames holds no unreferenced, unmodified frame, the victim is the first unreferenced, modified frame examined. If there is none, the victim is the frame at the hand. In both cases the decision is made on the N-th edge after acceptance.
- R7: After a fault, the hand points to the frame following the victim, wrapping from N-1 to 0.
- R8: All referenced flags are clear when the victim is presented.
- R9: Each examined frame that is unreferenced and modified is appended to the write-back list in the order it was examined. A frame already on the list is not added again, so the list never exceeds N entries.
- R10: `wb_req` is 1 exactly when the list holds at least `WB_THRESH` frames. `wb_frame` shows the oldest listed frame.
- R11: `wb_ack` removes the oldest listed frame and clears its modified flag. An acknowledge while the list is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report strobe |
| acc_frame | input | IW | Frame touched by the access |
| acc_write | input | 1 | Access is a write |
| fault_req | input | 1 | Request a victim frame |
| fault_ready | output | 1 | Selector is idle and accepts a fault |
| victim_valid | output | 1 | One-cycle strobe for the chosen victim |
| victim_frame | output | IW | Index of the chosen victim |
| wb_req | output | 1 | Write-back list has reached its threshold |
| wb_frame | output | IW | Oldest frame awaiting write-back |
| wb_ack | input | 1 | Write-back of `wb_frame` completed |

## Verification
The bench builds the block with its defaults: eight frames and a threshold of two. With eight frames, a full ring walk takes only a few cycles, so the fallback choices (first modified frame, or the hand frame) and the wrap of the hand past frame 7 are reached quickly. A threshold of two lets `wb_req` rise and fall with just one or two acknowledges. When every frame is modified, the whole list fills, which exercises duplicate suppression at full occupancy and the ignored acknowledge on an empty list. The bench compares each victim index and its latency against a behavioural ring model written from the requirements.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_SCAN
  } scan_state_t;

  // (idx + step) modulo n, for idx < n and step < n
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned step,
                                            input int unsigned n);
    int unsigned s;
    s = idx + step;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/esc_flags.sv
module esc_flags #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          clr_ref_all,
  input  logic          clr_chg_valid,
  input  logic [IW-1:0] clr_chg_frame,
  output logic [N-1:0]  ref_bits,
  output logic [N-1:0]  chg_bits
);

  for (genvar i = 0; i < N; i++) begin : g_frame
    logic r_q, c_q;
    logic hit, wr_hit, clr_hit;
    assign hit     = acc_valid && (acc_frame == IW'(i));
    assign wr_hit  = hit && acc_write;
    assign clr_hit = clr_chg_valid && (clr_chg_frame == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        c_q <= 1'b0;
      end else begin
        // a new access outranks the bulk clear of referenced flags
        if (hit)              r_q <= 1'b1;
        else if (clr_ref_all) r_q <= 1'b0;
        // a new write outranks a completed write-back
        if (wr_hit)           c_q <= 1'b1;
        else if (clr_hit)     c_q <= 1'b0;
      end
    end

    assign ref_bits[i] = r_q;
    assign chg_bits[i] = c_q;
  end

  p_write_sets_chg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> chg_bits[$past(acc_frame)]);

  p_access_sets_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_bits[$past(acc_frame)]);

  p_ref_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ref_all && !acc_valid |=> ref_bits == '0);

endmodule

// File: rtl/esc_wbq.sv
module esc_wbq #(
  parameter int N      = 8,
  parameter int THRESH = 2,
  parameter int IW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [IW-1:0] push_frame,
  input  logic          pop,
  output logic          pop_fire,
  output logic [IW-1:0] head_frame,
  output logic          req
);
  import esc_pkg::*;

  localparam int CW = $clog2(N + 1);

  logic [IW-1:0] slot_q [N];
  logic [IW-1:0] rd_q, wr_q;
  logic [CW-1:0] count_q;
  logic [N-1:0]  listed_q;
  logic          push_ok;

  assign push_ok    = push_valid && !listed_q[push_frame];
  assign pop_fire   = pop && (count_q != '0);
  assign head_frame = slot_q[rd_q];
  assign req        = count_q >= CW'(THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      count_q  <= '0;
      listed_q <= '0;
    end else begin
      if (push_ok) begin
        slot_q[wr_q]         <= push_frame;
        wr_q                 <= IW'(ring_next(int'(wr_q), 1, N));
        listed_q[push_frame] <= 1'b1;
      end
      if (pop_fire) begin
        rd_q                 <= IW'(ring_next(int'(rd_q), 1, N));
        listed_q[slot_q[rd_q]] <= 1'b0;
      end
      count_q <= count_q + CW'(push_ok) - CW'(pop_fire);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(N));

  p_dup_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && listed_q[push_frame] |=>
      count_q == $past(count_q) - CW'($past(pop_fire)));

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop && (count_q == '0) && !push_valid |=> count_q == '0);

endmodule

// File: rtl/esc_scan.sv
module esc_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_req,
  input  logic [N-1:0]  ref_bits,
  input  logic [N-1:0]  chg_bits,
  output logic          ready,
  output logic          victim_valid,
  output logic [IW-1:0] victim_frame,
  output logic          push_valid,
  output logic [IW-1:0] push_frame,
  output logic          clr_ref_all
);
  import esc_pkg::*;

  scan_state_t   st_q;
  logic [IW-1:0] hand_q, cnt_q, first_q, cur, pick;
  logic          seen_q;
  logic          in_scan, clean_here, dirty_here, last, decide;

  assign in_scan    = (st_q == ST_SCAN);
  assign cur        = IW'(ring_next(int'(hand_q), int'(cnt_q), N));
  assign clean_here = in_scan && !ref_bits[cur] && !chg_bits[cur];
  assign dirty_here = in_scan && !ref_bits[cur] &&  chg_bits[cur];
  assign last       = (cnt_q == IW'(N - 1));
  assign decide     = in_scan && (clean_here || last);

  always_comb begin
    if (clean_here)      pick = cur;
    else if (seen_q)     pick = first_q;
    else if (dirty_here) pick = cur;
    else                 pick = hand_q;
  end

  assign ready       = !in_scan;
  assign push_valid  = dirty_here;
  assign push_frame  = cur;
  assign clr_ref_all = decide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      hand_q       <= '0;
      cnt_q        <= '0;
      first_q      <= '0;
      seen_q       <= 1'b0;
      victim_valid <= 1'b0;
      victim_frame <= '0;
    end else begin
      victim_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (fault_req) begin
          st_q   <= ST_SCAN;
          cnt_q  <= '0;
          seen_q <= 1'b0;
        end
        ST_SCAN: if (decide) begin
          st_q         <= ST_IDLE;
          victim_valid <= 1'b1;
          victim_frame <= pick;
          hand_q       <= IW'(ring_next(int'(pick), 1, N));
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (dirty_here && !seen_q) begin
            seen_q  <= 1'b1;
            first_q <= cur;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_victim_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready && fault_req |=> !ready);

  p_hand_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> hand_q == IW'(ring_next(int'(victim_frame), 1, N)));

  p_no_victim_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_scan |-> !victim_valid);

endmodule

// File: rtl/esc_victim_sel.sv
module esc_victim_sel #(
  parameter int N         = 8,
  parameter int WB_THRESH = 2,
  parameter int IW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          fault_req,
  output logic          fault_ready,
  output logic          victim_valid,
  output logic [IW-1:0] victim_frame,
  output logic          wb_req,
  output logic [IW-1:0] wb_frame,
  input  logic          wb_ack
);

  logic [N-1:0]  ref_bits, chg_bits;
  logic          clr_ref_all, push_valid, pop_fire;
  logic [IW-1:0] push_frame;

  esc_flags #(.N(N), .IW(IW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .clr_ref_all(clr_ref_all),
    .clr_chg_valid(pop_fire), .clr_chg_frame(wb_frame),
    .ref_bits(ref_bits), .chg_bits(chg_bits)
  );

  esc_scan #(.N(N), .IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
    .ref_bits(ref_bits), .chg_bits(chg_bits),
    .ready(fault_ready), .victim_valid(victim_valid), .victim_frame(victim_frame),
    .push_valid(push_valid), .push_frame(push_frame), .clr_ref_all(clr_ref_all)
  );

  esc_wbq #(.N(N), .THRESH(WB_THRESH), .IW(IW)) u_wbq (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_frame(push_frame),
    .pop(wb_ack), .pop_fire(pop_fire),
    .head_frame(wb_frame), .req(wb_req)
  );

  p_ref_zero_at_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid && !$past(acc_valid) |-> ref_bits == '0);

  p_ack_clears_chg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && !(acc_valid && acc_write) |=> !chg_bits[$past(wb_frame)]);

  p_listed_is_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> chg_bits[push_frame] && !ref_bits[push_frame]);

endmodule

// File: tb/esc_victim_sel_tb.sv
module esc_victim_sel_tb;

  localparam int NF = 8;
  localparam int TH = 2;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic          fault_req = 1'b0, wb_ack = 1'b0;
  logic          fault_ready, victim_valid, wb_req;
  logic [IW-1:0] victim_frame, wb_frame;

  int checks = 0;
  int errors = 0;

  // behavioural ring model, written from the requirements
  bit mref [NF];
  bit mchg [NF];
  int mlist [$];
  int mhand = 0;

  always #10 clk = ~clk;

  esc_victim_sel #(.N(NF), .WB_THRESH(TH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .fault_req(fault_req), .fault_ready(fault_ready),
    .victim_valid(victim_valid), .victim_frame(victim_frame),
    .wb_req(wb_req), .wb_frame(wb_frame), .wb_ack(wb_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_list();
    chk(wb_req == (mlist.size() >= TH), "R10 wb_req level", int'(wb_req),
        int'(mlist.size() >= TH));
    if (mlist.size() > 0)
      chk(int'(wb_frame) == mlist[0], "R10 oldest listed frame", int'(wb_frame), mlist[0]);
  endtask

  task automatic access(input int f, input bit w);
    @(negedge clk);
    acc_valid = 1'b1; acc_frame = IW'(f); acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    mref[f] = 1'b1;
    if (w) mchg[f] = 1'b1;
  endtask

  task automatic ack();
    @(negedge clk);
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    if (mlist.size() > 0) begin
      mchg[mlist[0]] = 1'b0;
      void'(mlist.pop_front());
    end
    chk_list();
  endtask

  function automatic bit listed(input int f);
    foreach (mlist[k]) if (mlist[k] == f) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_fault(output int vic, output int lat);
    int fd;
    bit found;
    fd = -1; found = 1'b0; vic = mhand; lat = NF + 1;
    for (int j = 0; j < NF && !found; j++) begin
      int f;
      f = (mhand + j) % NF;
      if (!mref[f] && !mchg[f]) begin
        vic = f; lat = j + 2; found = 1'b1;
      end else if (!mref[f] && mchg[f]) begin
        if (!listed(f)) mlist.push_back(f);
        if (fd < 0) fd = f;
      end
    end
    if (!found && fd >= 0) vic = fd;
    mhand = (vic + 1) % NF;
    for (int k = 0; k < NF; k++) mref[k] = 1'b0;
  endtask

  task automatic do_fault(input bit hold, input string tag);
    int ev, el, n, seen, got;
    model_fault(ev, el);
    @(negedge clk);
    chk(fault_ready == 1'b1, "R3 ready before fault", int'(fault_ready), 1);
    fault_req = 1'b1;
    n = 0; seen = 0; got = -1;
    while (seen == 0 && n < 2 * NF + 4) begin
      @(negedge clk);
      n++;
      if (n == 1)
        chk(fault_ready == 1'b0, "R3 busy while scanning", int'(fault_ready), 0);
      if (!hold || n >= 2) fault_req = 1'b0;
      if (victim_valid) begin
        seen = n; got = int'(victim_frame);
      end
    end
    fault_req = 1'b0;
    chk(seen == el, {tag, " victim latency"}, seen, el);
    chk(got == ev, {tag, " victim index R7"}, got, ev);
    @(negedge clk);
    chk(victim_valid == 1'b0, "R5 single pulse", int'(victim_valid), 0);
    chk(fault_ready == 1'b1, "R3 idle after victim", int'(fault_ready), 1);
    chk_list();
  endtask

  task automatic t_reset();
    chk(fault_ready == 1'b1, "R1 ready", int'(fault_ready), 1);
    chk(victim_valid == 1'b0, "R1 no victim", int'(victim_valid), 0);
    chk(wb_req == 1'b0, "R1 no write-back request", int'(wb_req), 0);
  endtask

  task automatic t_clean_first();
    do_fault(1'b0, "R4 clean at hand");
  endtask

  task automatic t_skip_referenced();
    access(1, 1'b0); access(2, 1'b0); access(3, 1'b1);
    do_fault(1'b0, "R2 R4 skip referenced");
  endtask

  task automatic t_dirty_listing();
    access(5, 1'b1); access(6, 1'b1);
    do_fault(1'b0, "R4 R8 referenced skipped");
    access(0, 1'b0); access(1, 1'b0); access(2, 1'b0);
    do_fault(1'b0, "R8 R9 one listed");
    do_fault(1'b0, "R9 R10 list grows");
  endtask

  task automatic t_duplicates();
    access(0, 1'b0); access(1, 1'b0); access(2, 1'b0);
    do_fault(1'b0, "R9 duplicates ignored");
  endtask

  task automatic t_busy_ignore();
    for (int f = 0; f < NF; f++) access(f, 1'b0);
    do_fault(1'b1, "R3 R6 hand fallback");
  endtask

  task automatic t_dirty_fallback();
    for (int f = 0; f < NF; f++) access(f, 1'b1);
    do_fault(1'b0, "R6 all referenced");
    do_fault(1'b0, "R6 R9 first modified");
    chk(mlist.size() == NF, "R9 list holds every frame once", mlist.size(), NF);
  endtask

  task automatic t_drain();
    while (mlist.size() > 0) ack();
    ack();
    ack();
    chk(wb_req == 1'b0, "R11 empty ack ignored", int'(wb_req), 0);
    do_fault(1'b0, "R11 modified cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NF; k++) begin mref[k] = 1'b0; mchg[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_first();
    t_skip_referenced();
    t_dirty_listing();
    t_duplicates();
    t_busy_ignore();
    t_dirty_fallback();
    t_drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule